// File: doc/BRIEF.md
# Block-Averaged Signal Power Monitor

This block watches one converter channel in its decimated clock domain and reports whether the channel's mean power is high or low. Each clock it takes one signed sample, squares it and adds the square to a wide running sum. When a block of 2^M samples has been gathered, the sum is scaled down to a 16-bit power word. In that word 65536 would stand for a full-scale square. The block then compares the word against a high and a low threshold.

The result is driven out either as a single alarm bit with hysteresis or as a two-bit level code, selected by a mode input. The level output changes only at the end of a block and holds in between. After changing the block length, software pulses the soft reset. This arms the monitor and captures the new length. While it is disabled, not yet armed or held in soft reset, the sum, the sample count and the output all stay at zero. A chip carries one instance per channel.

Top module: `rms_power_monitor`

## Requirements
- R1: While `rst_n` is low, `det_en_i` is low or `soft_rst_i` is high, `level_o` reads 00 from the next clock edge on, and the partial block in progress is discarded.
- R2: Setting `det_en_i` does not start measurement on its own. Samples are accumulated only once a `soft_rst_i` pulse has been seen with the monitor enabled. Clearing `det_en_i` disarms the monitor again.
- R3: `blk_log2_i` (0 to 16, larger values treated as 16) is captured while `soft_rst_i` is high. A block is 2^M samples long and begins with the first sample clocked after `soft_rst_i` falls. Blocks follow one another with no gap.
- R4: The power of a block is floor(sum of squares / 2^(M+14)), saturated to 65535. The sample clocked on the final cycle of the block belongs to that block.
- R5: With `two_bit_i` low, `level_o[1]` is 0. `level_o[0]` becomes 1 when the power is strictly greater than `thr_hi_i`. It becomes 0 when the power is strictly less than `thr_lo_i`. Otherwise it keeps its previous value, including when the power equals either threshold.
- R6: With `two_bit_i` high, `level_o` is 11 when the power is at least `thr_hi_i`, 01 when it is at least `thr_lo_i` but below `thr_hi_i`, and 00 when it is below `thr_lo_i`. The code 10 never appears.
- R7: `level_o` takes its new value at the clock edge that consumes a block's last sample and holds that value for the rest of the following block.
- R8: When `soft_rst_i` is high on the cycle that would end a block, the soft reset wins. No result is produced, `level_o` goes to 00, and the next block is a full 2^M samples counted from the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decimated sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Monitor enable |
| soft_rst_i | input | 1 | Synchronous soft reset; arms the monitor and captures the block length |
| blk_log2_i | input | 5 | Block length exponent M |
| thr_hi_i | input | 16 | High threshold, in units of 1/65536 of full-scale power |
| thr_lo_i | input | 16 | Low threshold, in units of 1/65536 of full-scale power |
| two_bit_i | input | 1 | 1 selects the two-bit level code, 0 selects the hysteretic alarm |
| sample_i | input | 16 | Signed two's complement sample |
| level_o | output | 2 | Alarm bit or level code |

## Verification
A block end and a soft reset can land in the same clock cycle. The bench provokes this in two steps. First, a block is started whose thresholds would make it report 11, and three of its four samples are fed. Then the fourth sample is driven together with a soft reset. The bench expects 00 right after that edge. It also expects 00 after three further samples, since the interrupted samples must not shorten the next block. Only the fourth new sample may raise 11.

// File: rtl/rms_pwr_pkg.sv
package rms_pwr_pkg;

    // Clamp a requested block exponent to the supported maximum.
    function automatic int unsigned clamp_log2(input int unsigned req, input int unsigned max_log2);
        return (req > max_log2) ? max_log2 : req;
    endfunction

    // Two-bit level codes.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b11
    } level_code_e;

endpackage

// File: rtl/rms_square.sv
module rms_square #(
    parameter int SAMPLE_W = 16,
    localparam int SQ_W = 2 * SAMPLE_W
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic        [SQ_W-1:0]     square_o
);
    logic [SAMPLE_W-1:0] mag;

    always_comb begin
        if (sample_i[SAMPLE_W-1]) begin
            mag = SAMPLE_W'(-sample_i);
        end else begin
            mag = SAMPLE_W'(sample_i);
        end
        square_o = SQ_W'(mag) * SQ_W'(mag);
    end
endmodule

// File: rtl/rms_block_accum.sv
module rms_block_accum #(
    parameter int SAMPLE_W = 16,
    parameter int PWR_W    = 16,
    parameter int LOG2_MAX = 16,
    localparam int SQ_W       = 2 * SAMPLE_W,
    localparam int ACC_W      = SQ_W + LOG2_MAX,
    localparam int CNT_W      = LOG2_MAX + 1,
    localparam int LOG_W      = $clog2(LOG2_MAX + 1),
    localparam int NORM_SHIFT = SQ_W - 2 - PWR_W,
    localparam int SH_W       = $clog2(ACC_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [LOG_W-1:0] log2_i,
    input  logic [SQ_W-1:0]  square_i,
    output logic             blk_end_o,
    output logic [PWR_W-1:0] power_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [CNT_W-1:0] last_idx;
    logic [ACC_W-1:0] total;
    logic [ACC_W-1:0] scaled;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        st_d      = st_q;
        blk_end_o = 1'b0;
        last_idx  = (CNT_W'(1) << log2_i) - CNT_W'(1);
        total     = st_q.acc + ACC_W'(square_i);
        shamt     = SH_W'(log2_i) + SH_W'(NORM_SHIFT);
        scaled    = total >> shamt;

        if (|scaled[ACC_W-1:PWR_W]) begin
            power_o = '1;
        end else begin
            power_o = scaled[PWR_W-1:0];
        end

        if (!run_i) begin
            st_d = '0;
        end else if (st_q.cnt == last_idx) begin
            blk_end_o = 1'b1;
            st_d      = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.acc = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/rms_level_eval.sv
module rms_level_eval
    import rms_pwr_pkg::*;
#(
    parameter int PWR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             blk_end_i,
    input  logic [PWR_W-1:0] power_i,
    input  logic [PWR_W-1:0] thr_hi_i,
    input  logic [PWR_W-1:0] thr_lo_i,
    input  logic             two_bit_i,
    output logic [1:0]       level_o
);
    typedef struct packed {
        logic [1:0] level;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.level = LVL_LOW;
        end else if (blk_end_i) begin
            if (two_bit_i) begin
                if (power_i >= thr_hi_i) begin
                    st_d.level = LVL_HIGH;
                end else if (power_i >= thr_lo_i) begin
                    st_d.level = LVL_MID;
                end else begin
                    st_d.level = LVL_LOW;
                end
            end else begin
                if (power_i > thr_hi_i) begin
                    st_d.level = 2'b01;
                end else if (power_i < thr_lo_i) begin
                    st_d.level = 2'b00;
                end else begin
                    st_d.level = {1'b0, st_q.level[0]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/rms_power_monitor.sv
module rms_power_monitor
    import rms_pwr_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int PWR_W    = 16,
    parameter int LOG2_MAX = 16,
    localparam int SQ_W  = 2 * SAMPLE_W,
    localparam int CNT_W = LOG2_MAX + 1,
    localparam int LOG_W = $clog2(LOG2_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       det_en_i,
    input  logic                       soft_rst_i,
    input  logic [LOG_W-1:0]           blk_log2_i,
    input  logic [PWR_W-1:0]           thr_hi_i,
    input  logic [PWR_W-1:0]           thr_lo_i,
    input  logic                       two_bit_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic [1:0]                 level_o
);
    typedef struct packed {
        logic             armed;
        logic [LOG_W-1:0] m;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic             run_w;
    logic             blk_end_w;
    logic [SQ_W-1:0]  square_w;
    logic [PWR_W-1:0] power_w;
    logic [CNT_W-1:0] count_w;

    always_comb begin
        cfg_d = cfg_q;
        if (!det_en_i) begin
            cfg_d.armed = 1'b0;
        end else if (soft_rst_i) begin
            cfg_d.armed = 1'b1;
        end
        if (soft_rst_i) begin
            cfg_d.m = LOG_W'(clamp_log2(int'(blk_log2_i), LOG2_MAX));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run_w = cfg_q.armed & det_en_i & ~soft_rst_i;

    rms_square #(.SAMPLE_W(SAMPLE_W)) u_sq (
        .sample_i (sample_i),
        .square_o (square_w)
    );

    rms_block_accum #(
        .SAMPLE_W (SAMPLE_W),
        .PWR_W    (PWR_W),
        .LOG2_MAX (LOG2_MAX)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .log2_i    (cfg_q.m),
        .square_i  (square_w),
        .blk_end_o (blk_end_w),
        .power_o   (power_w),
        .count_o   (count_w)
    );

    rms_level_eval #(.PWR_W(PWR_W)) u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .blk_end_i (blk_end_w),
        .power_i   (power_w),
        .thr_hi_i  (thr_hi_i),
        .thr_lo_i  (thr_lo_i),
        .two_bit_i (two_bit_i),
        .level_o   (level_o)
    );
endmodule

// File: rtl/rms_power_monitor_chk.sv
module rms_power_monitor_chk #(
    parameter int PWR_W = 16,
    parameter int CNT_W = 17,
    parameter int LOG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             det_en_i,
    input logic             soft_rst_i,
    input logic             two_bit_i,
    input logic [PWR_W-1:0] thr_hi_i,
    input logic [1:0]       level_o,
    input logic             run_w,
    input logic             blk_end_w,
    input logic [PWR_W-1:0] power_w,
    input logic [CNT_W-1:0] count_w,
    input logic [LOG_W-1:0] m_q
);
    // R1: idle or soft reset clears the output on the next edge
    assert_idle_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en_i || soft_rst_i) |=> (level_o == 2'b00));

    // R7: output holds inside a block
    assert_hold_midblock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !blk_end_w) |=> $stable(level_o));

    // R6: code 10 is never produced
    assert_no_code_10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 2'b10);

    // R6: power at or above the high threshold gives 11
    assert_top_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_w && two_bit_i && (power_w >= thr_hi_i)) |=> (level_o == 2'b11));

    // R5: single-bit mode keeps the upper bit clear
    assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_w && !two_bit_i) |=> !level_o[1]);

    // R5: power strictly above the high threshold sets the alarm
    assert_alarm_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end_w && !two_bit_i && (power_w > thr_hi_i)) |=> level_o[0]);

    // R3: sample count stays inside the block
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_w < (CNT_W'(1) << m_q));
endmodule

bind rms_power_monitor rms_power_monitor_chk #(
    .PWR_W (PWR_W),
    .CNT_W (CNT_W),
    .LOG_W (LOG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_en_i   (det_en_i),
    .soft_rst_i (soft_rst_i),
    .two_bit_i  (two_bit_i),
    .thr_hi_i   (thr_hi_i),
    .level_o    (level_o),
    .run_w      (run_w),
    .blk_end_w  (blk_end_w),
    .power_w    (power_w),
    .count_w    (count_w),
    .m_q        (cfg_q.m)
);

// File: tb/tb_rms_power_monitor.sv
module tb_rms_power_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_en = 1'b0;
    logic        soft_rst = 1'b0;
    logic [4:0]  blk_log2 = 5'd0;
    logic [15:0] thr_hi = 16'd0;
    logic [15:0] thr_lo = 16'd0;
    logic        two_bit = 1'b0;
    logic signed [15:0] sample = 16'sd0;
    logic [1:0]  level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rms_power_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_en_i   (det_en),
        .soft_rst_i (soft_rst),
        .blk_log2_i (blk_log2),
        .thr_hi_i   (thr_hi),
        .thr_lo_i   (thr_lo),
        .two_bit_i  (two_bit),
        .sample_i   (sample),
        .level_o    (level)
    );

    typedef struct packed {
        logic        rst;
        logic [4:0]  m;
        logic        mode;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [1:0]  exp;
    } vec_t;

    // Power of a constant amplitude x is floor(x*x / 16384).
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'd2,  1'b0, 16'd4096,  16'd4096,  16'd2000,  16'd500,   2'b00}, // R5 below hi
        '{1'b0, 5'd2,  1'b0, 16'd16384, 16'd16384, 16'd2000,  16'd500,   2'b01}, // R5 sets
        '{1'b0, 5'd2,  1'b0, 16'd4096,  16'd4096,  16'd2000,  16'd500,   2'b01}, // R5 hysteresis hold
        '{1'b0, 5'd2,  1'b0, 16'd0,     16'd0,     16'd2000,  16'd500,   2'b00}, // R5 clears
        '{1'b0, 5'd2,  1'b0, 16'd4096,  16'd4096,  16'd1024,  16'd500,   2'b00}, // R5 equal hi no set
        '{1'b0, 5'd2,  1'b0, 16'd16384, 16'd16384, 16'd1024,  16'd500,   2'b01}, // R5
        '{1'b0, 5'd2,  1'b0, 16'd16384, 16'd16384, 16'd20000, 16'd16384, 2'b01}, // R5 equal lo no clear
        '{1'b0, 5'd2,  1'b1, 16'd16384, 16'd16384, 16'd20000, 16'd1000,  2'b01}, // R6 middle
        '{1'b0, 5'd2,  1'b1, 16'd32767, 16'd32767, 16'd20000, 16'd1000,  2'b11}, // R6 high
        '{1'b0, 5'd2,  1'b1, 16'd4096,  16'd4096,  16'd1024,  16'd500,   2'b11}, // R6 equal hi
        '{1'b0, 5'd2,  1'b1, 16'd4096,  16'd4096,  16'd2000,  16'd1024,  2'b01}, // R6 equal lo
        '{1'b0, 5'd2,  1'b1, 16'd4096,  16'd4096,  16'd2000,  16'd1025,  2'b00}, // R6 low
        '{1'b1, 5'd0,  1'b1, 16'h8000,  16'h8000,  16'd65535, 16'd1000,  2'b11}, // R4 saturation, R3 M=0
        '{1'b1, 5'd5,  1'b0, 16'h8000,  16'h8000,  16'd65534, 16'd1000,  2'b01}, // R4 65535 > 65534
        '{1'b1, 5'd1,  1'b1, 16'd16384, 16'd0,     16'd8192,  16'd100,   2'b11}, // R4 mean of 16384 and 0
        '{1'b0, 5'd1,  1'b1, 16'd16384, 16'd0,     16'd8193,  16'd100,   2'b01}, // R4 last sample counted
        '{1'b0, 5'd1,  1'b1, 16'hC000,  16'd16384, 16'd16384, 16'd100,   2'b11}, // R4 negative sample
        '{1'b1, 5'd16, 1'b1, 16'd16384, 16'd16384, 16'd16384, 16'd0,     2'b11}  // R3 M=16
    };

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic feed(input logic [15:0] val, input int n);
        for (int i = 0; i < n; i++) begin
            sample = $signed(val);
            @(negedge clk);
        end
    endtask

    task automatic pulse_soft_rst();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] prev;
        repeat (3) @(negedge clk);
        check(level, 2'b00, "R1 reset state");
        rst_n  = 1'b1;
        det_en = 1'b1;
        @(negedge clk);
        prev = 2'b00;

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            int   n;
            v       = VEC[k];
            thr_hi  = v.hi;
            thr_lo  = v.lo;
            two_bit = v.mode;
            if (v.rst) begin
                blk_log2 = v.m;
                pulse_soft_rst();
                prev = 2'b00;
            end
            n = 1 << v.m;
            for (int i = 0; i < n; i++) begin
                if (i == n - 1) check(level, prev, $sformatf("R7 hold before block end, vector %0d", k));
                sample = $signed((i % 2 == 0) ? v.a : v.b);
                @(negedge clk);
            end
            check(level, v.exp, $sformatf("R4/R5/R6 block result, vector %0d", k));
            prev = v.exp;
        end

        // R1: disable clears output
        det_en = 1'b0;
        @(negedge clk);
        check(level, 2'b00, "R1 disable clears");

        // R2: enabling alone does not start measurement
        det_en   = 1'b1;
        blk_log2 = 5'd2;
        thr_hi   = 16'd0;
        thr_lo   = 16'd0;
        two_bit  = 1'b1;
        feed(16'd16384, 12);
        check(level, 2'b00, "R2 not armed");
        pulse_soft_rst();
        feed(16'd16384, 4);
        check(level, 2'b11, "R2 armed after soft reset");

        // R8: soft reset on the block-end cycle
        feed(16'd0, 3);
        check(level, 2'b11, "R7 hold mid block");
        sample   = 16'sd0;
        soft_rst = 1'b1;
        @(negedge clk);
        check(level, 2'b00, "R8 soft reset wins at block end");
        soft_rst = 1'b0;
        feed(16'd16384, 3);
        check(level, 2'b00, "R8 restarted block not yet complete");
        feed(16'd16384, 1);
        check(level, 2'b11, "R8 full block after release");

        // R1: soft reset mid block
        feed(16'd16384, 2);
        soft_rst = 1'b1;
        @(negedge clk);
        check(level, 2'b00, "R1 soft reset clears");
        soft_rst = 1'b0;

        finish_run();
    end
endmodule